// File: doc/BRIEF.md
# UART Hardware Flow Control Unit

This block sits between a UART's serializer/deserializer pair and the modem-control pins. On the transmit side it decides when the next character may begin. It watches an active-low clear-to-send input and only issues a one-cycle start strobe while the remote end is ready. A character already on the line is always allowed to finish. On the receive side it drives an active-low request-to-send output from the fill level of the receive buffer, so the remote sender is told to pause once no space is left.

A change detector on the synchronized clear-to-send level sets a sticky flag. Software clears the flag with a strobe, and the flag can raise an interrupt when that is enabled. Three independent enables control the block: transmit gating, request-to-send generation and the interrupt. The first two can only be changed while the peripheral is switched off. The interrupt enable can be changed at any time.

The serializer talks to this block through a simple handshake. A transmit-valid level shows that a character is waiting, and `txStart` both launches the character and acknowledges it. `txDone` reports that the last stop bit has left. The deserializer supplies its current buffer level.

Top module: `uart_flow_ctrl`

## Requirements
- R1: `txStart` is a single-cycle pulse. It is raised only while the unit is idle (`txBusy` = 0) with `txValid` = 1 and `periphEn` = 1. With transmit gating enabled it is also raised only while the synchronized `ctsN` is 0. In the cycle after the pulse, `txBusy` is 1.
- R2: Once a character has started, `txBusy` stays 1 until `txDone` is sampled high, whatever `ctsN` does in the meantime.
- R3: With transmit gating enabled, a character requested while `ctsN` = 1 is held with no start pulse. `txStart` rises within SYNC_STAGES + 1 cycles after `ctsN` falls.
- R4: With transmit gating disabled, characters start while `ctsN` = 1.
- R5: With request-to-send enabled, `rtsN` is 0 while `rxLevel` < RX_DEPTH. It is 1 in the same cycle that `rxLevel` reaches RX_DEPTH.
- R6: With request-to-send disabled, `rtsN` is 0 at every buffer level.
- R7: Any edge of the synchronized `ctsN` sets `ctsFlag`. `ctsFlagClr` clears it. A set in the same cycle as a clear wins.
- R8: `ctsIrq` equals `ctsFlag` AND the interrupt enable. The interrupt enable may be written whatever the state of `periphEn`.
- R9: A configuration write (`cfgWe` = 1) updates the gating enable and the request-to-send enable only while `periphEn` = 0. With `periphEn` = 1 the write leaves both unchanged.
- R10: While `periphEn` = 0, no character starts even if every other condition holds.
- R11: After reset, `txStart`, `txBusy`, `ctsFlag`, `ctsIrq` and `rtsN` are all 0, and all three enables are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| periphEn | input | 1 | Peripheral enable; locks the gating and request-to-send enables when 1 |
| cfgWe | input | 1 | Configuration write strobe |
| cfgCtsEn | input | 1 | Transmit gating enable value to write |
| cfgRtsEn | input | 1 | Request-to-send enable value to write |
| cfgCtsIe | input | 1 | Clear-to-send interrupt enable value to write |
| ctsFlagClr | input | 1 | Clears the clear-to-send change flag |
| ctsN | input | 1 | Asynchronous active-low clear-to-send pin |
| txValid | input | 1 | A character is waiting to be sent |
| txDone | input | 1 | Serializer finished the current character |
| rxLevel | input | LVL_W | Receive buffer fill level |
| txStart | output | 1 | One-cycle start and acknowledge to the serializer |
| txBusy | output | 1 | A character is being sent |
| rtsN | output | 1 | Active-low request-to-send pin |
| ctsFlag | output | 1 | Sticky clear-to-send change flag |
| ctsIrq | output | 1 | Clear-to-send change interrupt |

## Verification
The bench builds the unit with SYNC_STAGES = 2 and RX_DEPTH = 3, so a 2-bit level input spans the empty and full states. The full threshold can then be stepped into and out of directly. The short synchronizer keeps the clear-to-send latency at three cycles. That makes it practical to aim a flag clear at the exact cycle of an edge, which tests the set-over-clear priority. It also lets the bench show a held character starting within the stated bound.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

  // Enables handed from control to datapath each cycle
  typedef struct packed {
    logic ctsGate;
    logic rtsGen;
  } fcCtl_t;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } txState_e;

endpackage

// File: rtl/uart_fc_dp.sv
module uart_fc_dp
  import uart_fc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RX_DEPTH    = 4,
  parameter int LVL_W       = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctsN,
  input  logic [LVL_W-1:0] rxLevel,
  input  fcCtl_t           ctl,
  output logic             ctsSync,
  output logic             ctsEdge,
  output logic             ctsOk,
  output logic             rtsN
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(RX_DEPTH);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   ctsPrevQ;
  logic                   rxFull;

  // Pin resynchronizer; resets to the deasserted level
  generate
    if (SYNC_STAGES < 2) begin : g_bad_sync
      initial $error("SYNC_STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '1;
      ctsPrevQ <= 1'b1;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-2:0], ctsN};
      ctsPrevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign ctsSync = syncQ[SYNC_STAGES-1];
  assign ctsEdge = ctsSync ^ ctsPrevQ;
  assign ctsOk   = !ctl.ctsGate || !ctsSync;

  // Request-to-send follows the level combinationally so it rises in the fill cycle
  assign rxFull = (rxLevel >= FULL_LVL);
  assign rtsN   = ctl.rtsGen && rxFull;

endmodule

// File: rtl/uart_fc_ctrl.sv
module uart_fc_ctrl
  import uart_fc_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   periphEn,
  input  logic   cfgWe,
  input  logic   cfgCtsEn,
  input  logic   cfgRtsEn,
  input  logic   cfgCtsIe,
  input  logic   ctsFlagClr,
  input  logic   txValid,
  input  logic   txDone,
  input  logic   ctsOk,
  input  logic   ctsEdge,
  output fcCtl_t ctl,
  output logic   txStart,
  output logic   txBusy,
  output logic   ctsFlag,
  output logic   ctsIrq
);

  logic     ctsEnQ, rtsEnQ, ctsIeQ, flagQ;
  txState_e stateQ, stateD;

  // Gating and request-to-send enables are locked while the peripheral runs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctsEnQ <= 1'b0;
      rtsEnQ <= 1'b0;
      ctsIeQ <= 1'b0;
    end else if (cfgWe) begin
      ctsIeQ <= cfgCtsIe;
      if (!periphEn) begin
        ctsEnQ <= cfgCtsEn;
        rtsEnQ <= cfgRtsEn;
      end
    end
  end

  assign txStart = (stateQ == TX_IDLE) && txValid && periphEn && ctsOk;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      TX_IDLE: if (txStart) stateD = TX_SEND;
      TX_SEND: if (txDone)  stateD = TX_IDLE;
      default: stateD = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= TX_IDLE;
      flagQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (ctsEdge)         flagQ <= 1'b1;
      else if (ctsFlagClr) flagQ <= 1'b0;
    end
  end

  assign txBusy  = (stateQ == TX_SEND);
  assign ctsFlag = flagQ;
  assign ctsIrq  = flagQ && ctsIeQ;
  assign ctl     = '{ctsGate: ctsEnQ, rtsGen: rtsEnQ};

endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
  import uart_fc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RX_DEPTH    = 4,
  parameter int LVL_W       = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             periphEn,
  input  logic             cfgWe,
  input  logic             cfgCtsEn,
  input  logic             cfgRtsEn,
  input  logic             cfgCtsIe,
  input  logic             ctsFlagClr,
  input  logic             ctsN,
  input  logic             txValid,
  input  logic             txDone,
  input  logic [LVL_W-1:0] rxLevel,
  output logic             txStart,
  output logic             txBusy,
  output logic             rtsN,
  output logic             ctsFlag,
  output logic             ctsIrq
);

  fcCtl_t ctl;
  logic   ctsSync, ctsEdge, ctsOk;

  uart_fc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .periphEn   (periphEn),
    .cfgWe      (cfgWe),
    .cfgCtsEn   (cfgCtsEn),
    .cfgRtsEn   (cfgRtsEn),
    .cfgCtsIe   (cfgCtsIe),
    .ctsFlagClr (ctsFlagClr),
    .txValid    (txValid),
    .txDone     (txDone),
    .ctsOk      (ctsOk),
    .ctsEdge    (ctsEdge),
    .ctl        (ctl),
    .txStart    (txStart),
    .txBusy     (txBusy),
    .ctsFlag    (ctsFlag),
    .ctsIrq     (ctsIrq)
  );

  uart_fc_dp #(
    .SYNC_STAGES (SYNC_STAGES),
    .RX_DEPTH    (RX_DEPTH),
    .LVL_W       (LVL_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctsN    (ctsN),
    .rxLevel (rxLevel),
    .ctl     (ctl),
    .ctsSync (ctsSync),
    .ctsEdge (ctsEdge),
    .ctsOk   (ctsOk),
    .rtsN    (rtsN)
  );

endmodule

// File: rtl/uart_fc_chk.sv
module uart_fc_chk #(
  parameter int RX_DEPTH = 4,
  parameter int LVL_W    = $clog2(RX_DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             periphEn,
  input logic             txStart,
  input logic             txBusy,
  input logic             txDone,
  input logic             rtsN,
  input logic [LVL_W-1:0] rxLevel,
  input logic             ctsFlag,
  input logic             ctsIrq,
  input logic             ctsFlagClr,
  input logic             ctsEdge,
  input logic             ctsSync,
  input logic             ctsGate,
  input logic             rtsGen
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(RX_DEPTH);

  // R1
  start_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    txStart && ctsGate |-> !ctsSync);

  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> txBusy);

  // R1
  start_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> !txBusy);

  // R2
  char_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    txBusy && !txDone |=> txBusy);

  // R5
  rts_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rtsN) |-> rxLevel >= FULL_LVL);

  // R6
  rts_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rtsGen |-> !rtsN);

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctsEdge |=> ctsFlag);

  // R7
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctsFlagClr && !ctsEdge |=> !ctsFlag);

  // R8
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctsIrq |-> ctsFlag);

  // R9
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    periphEn |=> $stable(ctsGate) && $stable(rtsGen));

  // R10
  start_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> periphEn);

endmodule

bind uart_flow_ctrl uart_fc_chk #(
  .RX_DEPTH (RX_DEPTH),
  .LVL_W    (LVL_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .periphEn   (periphEn),
  .txStart    (txStart),
  .txBusy     (txBusy),
  .txDone     (txDone),
  .rtsN       (rtsN),
  .rxLevel    (rxLevel),
  .ctsFlag    (ctsFlag),
  .ctsIrq     (ctsIrq),
  .ctsFlagClr (ctsFlagClr),
  .ctsEdge    (ctsEdge),
  .ctsSync    (ctsSync),
  .ctsGate    (ctl.ctsGate),
  .rtsGen     (ctl.rtsGen)
);

// File: tb/tb_uart_flow_ctrl.sv
`timescale 1ns/1ps
module tb_uart_flow_ctrl;

  localparam int SYNC_STAGES = 2;
  localparam int RX_DEPTH    = 3;
  localparam int LVL_W       = $clog2(RX_DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic periphEn = 1'b0, cfgWe = 1'b0, cfgCtsEn = 1'b0, cfgRtsEn = 1'b0, cfgCtsIe = 1'b0;
  logic ctsFlagClr = 1'b0, ctsN = 1'b1, txValid = 1'b0, txDone = 1'b0;
  logic [LVL_W-1:0] rxLevel = '0;
  logic txStart, txBusy, rtsN, ctsFlag, ctsIrq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string expQ[$];

  always #2 clk = ~clk;

  uart_flow_ctrl #(
    .SYNC_STAGES (SYNC_STAGES),
    .RX_DEPTH    (RX_DEPTH)
  ) dut (
    .clk (clk), .rstN (rstN), .periphEn (periphEn), .cfgWe (cfgWe),
    .cfgCtsEn (cfgCtsEn), .cfgRtsEn (cfgRtsEn), .cfgCtsIe (cfgCtsIe),
    .ctsFlagClr (ctsFlagClr), .ctsN (ctsN), .txValid (txValid), .txDone (txDone),
    .rxLevel (rxLevel), .txStart (txStart), .txBusy (txBusy), .rtsN (rtsN),
    .ctsFlag (ctsFlag), .ctsIrq (ctsIrq)
  );

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles >= 20000) begin
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected < 20000", cycles);
      finish_run();
    end
  end

  // Scoreboard monitor: every start pulse must match an expected start
  always @(negedge clk) begin
    if (rstN && txStart) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R1 unexpected start: actual txStart=1 expected 0 at cycle %0d", cycles);
      end else begin
        void'(expQ.pop_front());
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic cfg_write(logic cts, logic rts, logic ie);
    cfgCtsEn = cts; cfgRtsEn = rts; cfgCtsIe = ie; cfgWe = 1'b1;
    step(1);
    cfgWe = 1'b0;
  endtask

  // Driver side: register an expected start and wait for it
  task automatic expect_start(string req, int maxC);
    bit got = 0;
    expQ.push_back(req);
    for (int i = 0; i < maxC && !got; i++) begin
      @(negedge clk);
      if (txStart) got = 1;
    end
    checks++;
    if (!got) begin
      fails++;
      $display("FAIL %s start missing: actual txStart=0 expected 1 within %0d cycles", req, maxC);
      void'(expQ.pop_back());
    end
    @(posedge clk); #1;
    txValid = 1'b0;
  endtask

  task automatic finish_char(string req);
    step(2);
    @(negedge clk); check(req, txBusy, 1'b1);
    step(1);
    txDone = 1'b1;
    step(1);
    txDone = 1'b0;
    @(negedge clk); check(req, txBusy, 1'b0);
    step(1);
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 txStart", txStart, 1'b0);
    check("R11 txBusy", txBusy, 1'b0);
    check("R11 rtsN", rtsN, 1'b0);
    check("R11 ctsFlag", ctsFlag, 1'b0);
    check("R11 ctsIrq", ctsIrq, 1'b0);
    step(1);

    cfg_write(1'b1, 1'b1, 1'b1);
    periphEn = 1'b1;

    // R3 held while CTS high, then released
    txValid = 1'b1;
    step(6);
    @(negedge clk); check("R3 held busy", txBusy, 1'b0);
    step(1);
    ctsN = 1'b0;
    expect_start("R3", SYNC_STAGES + 1);
    step(2);
    @(negedge clk);
    check("R7 flag on fall", ctsFlag, 1'b1);
    check("R8 irq", ctsIrq, 1'b1);
    step(1);
    // R2: CTS deasserts mid-character
    ctsN = 1'b1;
    step(4);
    @(negedge clk); check("R2 busy after cts high", txBusy, 1'b1);
    step(1);
    txDone = 1'b1; step(1); txDone = 1'b0;
    @(negedge clk); check("R2 done", txBusy, 1'b0);
    step(1);
    ctsFlagClr = 1'b1; step(1); ctsFlagClr = 1'b0;
    @(negedge clk);
    check("R7 cleared", ctsFlag, 1'b0);
    check("R8 irq cleared", ctsIrq, 1'b0);
    step(1);

    // R1: pending again while CTS high, then released
    txValid = 1'b1;
    step(5);
    ctsN = 1'b0;
    expect_start("R1", SYNC_STAGES + 1);
    finish_char("R1 complete");

    // R5 request-to-send vs level
    rxLevel = 2'd2;
    @(negedge clk); check("R5 not full", rtsN, 1'b0);
    step(1);
    rxLevel = 2'd3;
    @(negedge clk); check("R5 full same cycle", rtsN, 1'b1);
    step(1);
    rxLevel = 2'd1;
    @(negedge clk); check("R5 drained", rtsN, 1'b0);
    step(1);

    // R8 interrupt enable written while running; R7 set wins over clear
    cfg_write(1'b0, 1'b0, 1'b0);  // R9: enables must stay on
    ctsFlagClr = 1'b1;
    step(1);
    ctsN = 1'b1;
    step(3);
    @(negedge clk);
    check("R7 set over clear", ctsFlag, 1'b1);
    check("R8 irq masked", ctsIrq, 1'b0);
    step(1);
    @(negedge clk); check("R7 clear after set", ctsFlag, 1'b0);
    step(1);
    ctsFlagClr = 1'b0;

    // R9 locked write: gating and request-to-send still active
    rxLevel = 2'd3;
    @(negedge clk); check("R9 rts still enabled", rtsN, 1'b1);
    step(1);
    txValid = 1'b1;
    step(5);
    @(negedge clk); check("R9 gating still enabled", txBusy, 1'b0);
    step(1);
    txValid = 1'b0;

    // Unlock and disable both
    periphEn = 1'b0;
    step(1);
    cfg_write(1'b0, 1'b0, 1'b1);
    // R10 no start while peripheral off
    txValid = 1'b1;
    step(5);
    @(negedge clk);
    check("R10 no start", txBusy, 1'b0);
    check("R6 rts off when full", rtsN, 1'b0);
    step(1);
    // R4 starts with CTS high once enabled
    periphEn = 1'b1;
    expect_start("R4", 2);
    finish_char("R4 complete");

    step(2);
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R1 pending expected starts: actual %0d expected 0", expQ.size());
    end
    finish_run();
  end

endmodule